// File: doc/BRIEF.md
# DMA Software Trigger Enable Bank

This block holds one software-trigger bit per DMA channel and sits on a simple register bus. One address sets bits and a second address clears them. Both use write-one semantics, and both read back the same status vector. Writes take effect only when the bus marks the access as privileged. Reads are allowed at any privilege level.

The transfer engine reports completions and faults as one-cycle pulses, each tagged with a binary channel index. The block clears the matching channel bit by a per-channel rule. The rule looks at that channel's transfer type, its auto-initiation setting and its hardware-enable setting. The block also tells the engine, per channel, whether hardware requests may drive the next service. A software trigger that is still pending always takes precedence over hardware requests.

Top module: `dma_swtrig_enable`

## Requirements
- R1: After a synchronous reset, `sw_status`, `bus_rdata`, `acc_err` and `svc_hw` are all zero.
- R2: A privileged write to offset 0x24 sets every status bit whose write-data bit is 1. Bits written with 0 keep their value. The result is visible on `sw_status` one cycle after the write.
- R3: A privileged write to offset 0x2C clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A read at offset 0x24 or 0x2C returns the status vector on `bus_rdata` one cycle later, at any privilege level. The value returned is the status as it stood in the read cycle. A read at any other offset, or a cycle with no read, gives zero.
- R5: An unprivileged write to either mapped offset changes no status bit. It raises `acc_err` for exactly one cycle.
- R6: A channel whose `cfg_block` bit is 0 (frame type) clears on a frame-done pulse for its index. A frame-done pulse for a block-type channel has no effect.
- R7: A block-type channel with auto-initiation off clears on a block-done pulse for its index.
- R8: A block-type channel with auto-initiation on and hardware enable off keeps its bit on a block-done pulse.
- R9: A block-type channel with hardware enable on clears on block done. `svc_hw` for a channel is 1 exactly when its hardware enable is on and its software bit is clear, so software service comes first.
- R10: A control-packet-rewrite, bus-error or parity-error pulse clears the bit of its indexed channel, whatever that channel's configuration.
- R11: When a privileged set write and an auto-clear event hit the same channel in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | NUM_CH (32) | Write data, bit n = channel n |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | NUM_CH (32) | Registered read data |
| acc_err | output | 1 | One-cycle flag for a refused unprivileged write |
| cfg_block | input | NUM_CH (32) | Per channel transfer type: 1 block, 0 frame |
| cfg_autoinit | input | NUM_CH (32) | Per channel auto-initiation enable |
| cfg_hw_en | input | NUM_CH (32) | Per channel hardware request enable |
| ev_frame_done | input | 1 | Frame completed pulse |
| ev_frame_ch | input | IDX_W (5) | Channel of frame completion |
| ev_block_done | input | 1 | Block completed pulse |
| ev_block_ch | input | IDX_W (5) | Channel of block completion |
| ev_pkt_rewrite | input | 1 | Control packet rewritten while pending |
| ev_pkt_ch | input | IDX_W (5) | Channel of packet rewrite |
| ev_bus_err | input | 1 | Bus error pulse |
| ev_bus_ch | input | IDX_W (5) | Channel of bus error |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_parity_ch | input | IDX_W (5) | Channel of parity error |
| sw_status | output | NUM_CH (32) | Registered software trigger status |
| svc_hw | output | NUM_CH (32) | Registered: hardware may drive next service |

## Verification
Every result of this block is due one clock edge after its stimulus. This covers the status change from a write or an engine pulse, the read data, the access-error flag and the service-source vector. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then samples at that second falling edge, which is the first point after the single register stage has updated. For `acc_err`, the bench also samples one falling edge later to show the pulse has dropped. The read test drives a write and a read of the same offset in one cycle, to show that the read returns the pre-write value.

// File: rtl/swtrig_pkg.sv
package swtrig_pkg;
  localparam int NUM_EV    = 5;
  localparam int EVI_FRAME = 0;
  localparam int EVI_BLOCK = 1;
  localparam int EVI_REWR  = 2;
  localparam int EVI_BUSER = 3;
  localparam int EVI_PARER = 4;
endpackage

// File: rtl/swtrig_regdec.sv
module swtrig_regdec #(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 32,
  parameter logic [ADDR_W-1:0] SET_OFFS = 8'h24,
  parameter logic [ADDR_W-1:0] CLR_OFFS = 8'h2C
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_CH-1:0] bus_wdata,
  input  logic              bus_priv,
  output logic [NUM_CH-1:0] set_bits,
  output logic [NUM_CH-1:0] clr_bits,
  output logic              wr_denied,
  output logic              rd_hit
);
  logic hit_set, hit_clr;

  always_comb begin
    hit_set   = (bus_addr == SET_OFFS);
    hit_clr   = (bus_addr == CLR_OFFS);
    set_bits  = (bus_wr && bus_priv && hit_set) ? bus_wdata : '0;
    clr_bits  = (bus_wr && bus_priv && hit_clr) ? bus_wdata : '0;
    wr_denied = bus_wr && !bus_priv && (hit_set || hit_clr);
    rd_hit    = bus_rd && (hit_set || hit_clr);
  end
endmodule

// File: rtl/swtrig_evdec.sv
module swtrig_evdec
  import swtrig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 5
) (
  input  logic [NUM_EV-1:0]            ev_vld,
  input  logic [NUM_EV-1:0][IDX_W-1:0] ev_ch,
  input  logic [NUM_CH-1:0]            cfg_block,
  input  logic [NUM_CH-1:0]            cfg_autoinit,
  input  logic [NUM_CH-1:0]            cfg_hw_en,
  output logic [NUM_CH-1:0]            auto_clr
);
  logic [NUM_EV-1:0][NUM_CH-1:0] hit;

  for (genvar k = 0; k < NUM_EV; k++) begin : g_kind
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[k][c] = ev_vld[k] && (ev_ch[k] == IDX_W'(c));
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rule
    logic frame_rule, block_rule, fault_rule;
    always_comb begin
      frame_rule  = hit[EVI_FRAME][c] && !cfg_block[c];
      block_rule  = hit[EVI_BLOCK][c] && cfg_block[c] &&
                    (!cfg_autoinit[c] || cfg_hw_en[c]);
      fault_rule  = hit[EVI_REWR][c] || hit[EVI_BUSER][c] || hit[EVI_PARER][c];
      auto_clr[c] = frame_rule || block_rule || fault_rule;
    end
  end
endmodule

// File: rtl/swtrig_bits.sv
module swtrig_bits #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_bits,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] auto_clr,
  input  logic [NUM_CH-1:0] cfg_hw_en,
  output logic [NUM_CH-1:0] status_q,
  output logic [NUM_CH-1:0] svc_hw_q
);
  logic [NUM_CH-1:0] status_d;

  // a set write overrides an engine clear; a clear write overrides both
  assign status_d = ((status_q & ~auto_clr) | set_bits) & ~clr_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      svc_hw_q <= '0;
    end else begin
      status_q <= status_d;
      svc_hw_q <= cfg_hw_en & ~status_d;
    end
  end
endmodule

// File: rtl/dma_swtrig_enable.sv
module dma_swtrig_enable
  import swtrig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFFS = 8'h24,
  parameter logic [ADDR_W-1:0] CLR_OFFS = 8'h2C,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_CH-1:0] bus_wdata,
  input  logic              bus_priv,
  output logic [NUM_CH-1:0] bus_rdata,
  output logic              acc_err,
  input  logic [NUM_CH-1:0] cfg_block,
  input  logic [NUM_CH-1:0] cfg_autoinit,
  input  logic [NUM_CH-1:0] cfg_hw_en,
  input  logic              ev_frame_done,
  input  logic [IDX_W-1:0]  ev_frame_ch,
  input  logic              ev_block_done,
  input  logic [IDX_W-1:0]  ev_block_ch,
  input  logic              ev_pkt_rewrite,
  input  logic [IDX_W-1:0]  ev_pkt_ch,
  input  logic              ev_bus_err,
  input  logic [IDX_W-1:0]  ev_bus_ch,
  input  logic              ev_parity_err,
  input  logic [IDX_W-1:0]  ev_parity_ch,
  output logic [NUM_CH-1:0] sw_status,
  output logic [NUM_CH-1:0] svc_hw
);
  logic [NUM_CH-1:0]            set_bits, clr_bits, auto_clr;
  logic                         wr_denied, rd_hit;
  logic [NUM_EV-1:0]            ev_vld;
  logic [NUM_EV-1:0][IDX_W-1:0] ev_ch;

  always_comb begin
    ev_vld[EVI_FRAME] = ev_frame_done;   ev_ch[EVI_FRAME] = ev_frame_ch;
    ev_vld[EVI_BLOCK] = ev_block_done;   ev_ch[EVI_BLOCK] = ev_block_ch;
    ev_vld[EVI_REWR]  = ev_pkt_rewrite;  ev_ch[EVI_REWR]  = ev_pkt_ch;
    ev_vld[EVI_BUSER] = ev_bus_err;      ev_ch[EVI_BUSER] = ev_bus_ch;
    ev_vld[EVI_PARER] = ev_parity_err;   ev_ch[EVI_PARER] = ev_parity_ch;
  end

  swtrig_regdec #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SET_OFFS(SET_OFFS), .CLR_OFFS(CLR_OFFS)
  ) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .set_bits(set_bits), .clr_bits(clr_bits),
    .wr_denied(wr_denied), .rd_hit(rd_hit)
  );

  swtrig_evdec #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ev (
    .ev_vld(ev_vld), .ev_ch(ev_ch),
    .cfg_block(cfg_block), .cfg_autoinit(cfg_autoinit), .cfg_hw_en(cfg_hw_en),
    .auto_clr(auto_clr)
  );

  swtrig_bits #(.NUM_CH(NUM_CH)) u_bits (
    .clk(clk), .rst(rst),
    .set_bits(set_bits), .clr_bits(clr_bits), .auto_clr(auto_clr),
    .cfg_hw_en(cfg_hw_en),
    .status_q(sw_status), .svc_hw_q(svc_hw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? sw_status : '0;
      acc_err   <= wr_denied;
    end
  end
endmodule

// File: rtl/swtrig_chk.sv
module swtrig_chk #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFFS = 8'h24,
  parameter logic [ADDR_W-1:0] CLR_OFFS = 8'h2C
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_CH-1:0] bus_wdata,
  input logic              bus_priv,
  input logic [NUM_CH-1:0] bus_rdata,
  input logic              acc_err,
  input logic [NUM_CH-1:0] sw_status
);
  logic set_wr, clr_wr, bad_wr;
  assign set_wr = bus_wr && bus_priv && (bus_addr == SET_OFFS);
  assign clr_wr = bus_wr && bus_priv && (bus_addr == CLR_OFFS);
  assign bad_wr = bus_wr && !bus_priv &&
                  ((bus_addr == SET_OFFS) || (bus_addr == CLR_OFFS));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (sw_status == '0 && bus_rdata == '0 && !acc_err));

  // R2
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((sw_status & $past(bus_wdata)) == $past(bus_wdata)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    !set_wr |=> ((sw_status & ~$past(sw_status)) == '0));

  // R3
  clr_write_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((sw_status & $past(bus_wdata)) == '0));

  // R4
  read_back_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == SET_OFFS || bus_addr == CLR_OFFS))
      |=> (bus_rdata == $past(sw_status)));

  // R5
  deny_flag_chk: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> (acc_err && sw_status == ($past(sw_status) & sw_status)));

  // R5
  deny_flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !bad_wr |=> !acc_err);
endmodule

bind dma_swtrig_enable swtrig_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SET_OFFS(SET_OFFS), .CLR_OFFS(CLR_OFFS)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
  .acc_err(acc_err), .sw_status(sw_status)
);

// File: tb/sim_dma_swtrig_enable.sv
module sim_dma_swtrig_enable;
  localparam int NCH = 32;
  localparam logic [7:0] A_SET = 8'h24;
  localparam logic [7:0] A_CLR = 8'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_priv = 0;
  logic [7:0] bus_addr = '0;
  logic [NCH-1:0] bus_wdata = '0, cfg_block = '0, cfg_autoinit = '0, cfg_hw_en = '0;
  logic ev_fr = 0, ev_bl = 0, ev_rw = 0, ev_be = 0, ev_pe = 0;
  logic [4:0] ch_fr = 0, ch_bl = 0, ch_rw = 0, ch_be = 0, ch_pe = 0;
  logic [NCH-1:0] bus_rdata, sw_status, svc_hw;
  logic acc_err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_swtrig_enable u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .acc_err(acc_err), .cfg_block(cfg_block), .cfg_autoinit(cfg_autoinit),
    .cfg_hw_en(cfg_hw_en),
    .ev_frame_done(ev_fr), .ev_frame_ch(ch_fr),
    .ev_block_done(ev_bl), .ev_block_ch(ch_bl),
    .ev_pkt_rewrite(ev_rw), .ev_pkt_ch(ch_rw),
    .ev_bus_err(ev_be), .ev_bus_ch(ch_be),
    .ev_parity_err(ev_pe), .ev_parity_ch(ch_pe),
    .sw_status(sw_status), .svc_hw(svc_hw)
  );

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns one falling edge later, after the update
  task automatic bus_write(input logic [7:0] a, input logic [NCH-1:0] d, input logic p);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; bus_priv = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic p);
    bus_rd = 1; bus_addr = a; bus_priv = p;
    @(negedge clk);
    bus_rd = 0; bus_priv = 0;
  endtask

  // kind: 0 frame, 1 block, 2 rewrite, 3 bus error, 4 parity
  task automatic pulse(input int kind, input logic [4:0] ch);
    case (kind)
      0: begin ev_fr = 1; ch_fr = ch; end
      1: begin ev_bl = 1; ch_bl = ch; end
      2: begin ev_rw = 1; ch_rw = ch; end
      3: begin ev_be = 1; ch_be = ch; end
      default: begin ev_pe = 1; ch_pe = ch; end
    endcase
    @(negedge clk);
    ev_fr = 0; ev_bl = 0; ev_rw = 0; ev_be = 0; ev_pe = 0;
  endtask

  // {is_set, priv, wdata, expected status}
  localparam logic [65:0] VEC [8] = '{
    {1'b1, 1'b1, 32'h0000_00F0, 32'h0000_00F0},
    {1'b1, 1'b1, 32'h8000_0001, 32'h8000_00F1},
    {1'b0, 1'b1, 32'h0000_0030, 32'h8000_00C1},
    {1'b1, 1'b0, 32'h0F00_0000, 32'h8000_00C1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 32'h8000_00C1},
    {1'b0, 1'b1, 32'h0000_0000, 32'h8000_00C1},
    {1'b1, 1'b1, 32'h0000_0000, 32'h8000_00C1},
    {1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 status", sw_status, '0);
    check("R1 rdata", bus_rdata, '0);
    check("R1 acc_err", {31'd0, acc_err}, '0);
    check("R1 svc_hw", svc_hw, '0);

    // ch3 frame; ch5 block; ch7 block+auto; ch9 block+auto+hw
    cfg_block    = (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 9);
    cfg_autoinit = (32'd1 << 7) | (32'd1 << 9);
    cfg_hw_en    = (32'd1 << 9);

    // R2 R3 R5: vector table
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][65] ? A_SET : A_CLR, VEC[i][63:32], VEC[i][64]);
      check(VEC[i][65] ? "R2 set vector" : "R3 clear vector", sw_status, VEC[i][31:0]);
      check("R5 acc_err", {31'd0, acc_err}, {31'd0, ~VEC[i][64]});
    end
    // R5: flag lasts one cycle
    @(negedge clk);
    check("R5 acc_err drop", {31'd0, acc_err}, '0);
    check("R9 svc_hw idle", svc_hw, 32'h0000_0200);

    // R4: read back on both offsets, unprivileged, and unmapped
    bus_write(A_SET, 32'h0000_00A5, 1);
    bus_read(A_SET, 0);
    check("R4 read set offset", bus_rdata, 32'h0000_00A5);
    bus_read(A_CLR, 1);
    check("R4 read clear offset", bus_rdata, 32'h0000_00A5);
    bus_read(8'h28, 1);
    check("R4 unmapped read", bus_rdata, '0);
    @(negedge clk);
    check("R4 idle rdata", bus_rdata, '0);
    // R4: read during same-cycle clear write returns old value
    bus_rd = 1; bus_wr = 1; bus_addr = A_CLR; bus_wdata = 32'h0000_00A5; bus_priv = 1;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_wdata = '0; bus_priv = 0;
    check("R4 read before write", bus_rdata, 32'h0000_00A5);
    check("R3 cleared", sw_status, '0);

    // R6: frame channel
    bus_write(A_SET, (32'd1 << 3) | (32'd1 << 5), 1);
    pulse(0, 5'd5);
    check("R6 frame on block ch ignored", sw_status, (32'd1 << 3) | (32'd1 << 5));
    pulse(0, 5'd3);
    check("R6 frame clears", sw_status, 32'd1 << 5);
    // R7
    pulse(1, 5'd5);
    check("R7 block no-auto clears", sw_status, '0);
    // R8
    bus_write(A_SET, 32'd1 << 7, 1);
    pulse(1, 5'd7);
    check("R8 auto keeps", sw_status, 32'd1 << 7);
    bus_write(A_CLR, 32'd1 << 7, 1);
    // R9
    bus_write(A_SET, 32'd1 << 9, 1);
    check("R9 svc_hw while sw set", svc_hw, '0);
    pulse(1, 5'd9);
    check("R9 hw channel clears", sw_status, '0);
    check("R9 svc_hw after clear", svc_hw, 32'd1 << 9);

    // R10: faults on frame and block channels, boundary indices
    bus_write(A_SET, 32'h8000_1081, 1);
    pulse(3, 5'd31);
    check("R10 bus error", sw_status, 32'h0000_1081);
    pulse(4, 5'd0);
    check("R10 parity error", sw_status, 32'h0000_1080);
    pulse(2, 5'd12);
    check("R10 packet rewrite", sw_status, 32'h0000_0080);
    pulse(2, 5'd7);
    check("R10 rewrite on auto ch", sw_status, '0);

    // R11: set write beats same-cycle frame completion
    bus_write(A_SET, 32'd1 << 3, 1);
    ev_fr = 1; ch_fr = 5'd3;
    bus_write(A_SET, 32'd1 << 3, 1);
    ev_fr = 0;
    check("R11 set wins", sw_status, 32'd1 << 3);

    // R1: reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 status after reset", sw_status, '0);
    check("R1 svc_hw after reset", svc_hw, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule